// File: doc/BRIEF.md
# Working-Set Clock Victim Selector

This block picks which page frame gives way when a page fault arrives. A clock hand sweeps a ring of frames. Each frame holds four things: a used flag, a dirty flag, a last-touch timestamp and the number of the task that owns it. The block combines the sweep with a working-set age test. A frame is a candidate only when its used flag is clear and its age has reached a tuning window. The age is the owning task's running execution time minus the frame's last-touch timestamp, taken modulo 2^16.

A frame whose used flag is found set has the flag cleared and its timestamp renewed, and the sweep moves on. A candidate that is dirty is handed out as a write-back request and skipped. The sweep stops at the first clean candidate, and the hand stays on that frame. If one full lap turns up no clean candidate, the block reports a no-victim result so that software can suspend a task. Write-backs already accepted during that lap still stand. An address translator sets used and dirty flags through a side port, and software presets timestamps and owners through a second side port.

Top module: `wsclock_victim_sel`

## Requirements
- R1: After reset the block is idle, `busy`, `done`, `wb_valid` and `victim_found` are low, and every frame has clear flags, timestamp 0 and owner 0. The hand rests on frame NF-1, so the first fault examines frame 0 first.
- R2: A high `fault_req` is accepted only while `busy` is low. The first frame examined is (hand + 1) mod NF. A `fault_req` raised while busy has no effect.
- R3: Exactly one frame is examined per clock cycle. If its used flag is set, the flag is cleared, its timestamp is loaded with its owner's execution time, and the sweep moves to the next frame.
- R4: A frame with a clear used flag is a candidate when (exec − timestamp) mod 2^TW ≥ `theta`. Here exec is the slice `exec_times[owner*TW +: TW]` of the frame's owner.
- R5: At a dirty candidate, `wb_valid` rises with `wb_frame` set to that frame. The sweep holds until `wb_ready` is high. On acceptance the frame's dirty flag is cleared and the sweep moves on.
- R6: At the first clean candidate, `done` pulses for one cycle with `victim_found` high and `victim_frame` set to that frame. The hand moves to that frame, so the next fault starts after it.
- R7: When NF frames have been examined with no clean candidate, `done` pulses with `victim_found` low and the hand is unchanged. Dirty flags cleared by write-backs accepted during the lap stay cleared.
- R8: The mark port sets used and/or dirty flags at any time. The init port writes a frame's timestamp and owner. Both win over a clear or refresh by the sweep on the same frame in the same cycle.
- R9: `busy` is high from the cycle after an accepted fault until the cycle in which `done` is high. `wb_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_req | input | 1 | Start a victim search |
| exec_times | input | NT*TW (64) | Execution time of each task, task t in bits [t*TW +: TW] |
| theta | input | TW (16) | Working-set window |
| mark_valid | input | 1 | Mark port strobe |
| mark_frame | input | IDX_W (4) | Frame to mark |
| mark_used | input | 1 | Set the used flag |
| mark_dirty | input | 1 | Set the dirty flag |
| init_valid | input | 1 | Init port strobe |
| init_frame | input | IDX_W (4) | Frame to initialise |
| init_time | input | TW (16) | Timestamp value to write |
| init_task | input | TKW (2) | Owner task to write |
| wb_valid | output | 1 | Write-back request pending |
| wb_ready | input | 1 | Write-back request taken |
| wb_frame | output | IDX_W (4) | Frame to write back |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| victim_found | output | 1 | Last search found a clean candidate |
| victim_frame | output | IDX_W (4) | Frame chosen by the last successful search |

## Verification
The hardest case to reach is the one where the renewal of a timestamp decides the outcome. The frames that were swept past must fail the age test only because their timestamps were refreshed during an earlier lap, while every other frame is held young through the init port. The stimulus touches two frames, runs one search with a high execution time, and then raises the clock and the window so that an unrefreshed timestamp would pass and a refreshed one would not. A full lap of dirty candidates, a stalled write-back, wrap-around age arithmetic and an owner that selects a different execution time are each arranged through the init and mark ports. A behavioural model is compared with the design on every clock.

// File: rtl/wsclock_pkg.sv
// Shared types for the working-set clock victim selector.
// Assumes nothing beyond IEEE 1800-2017.
package wsclock_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WB   = 2'd2
    } sweep_state_e;
endpackage

// File: rtl/wsclock_frame_table.sv
// Per-frame state registers: used flag, dirty flag, timestamp, owner.
// One read index is shared by the sweep; the mark and init ports win over
// sweep updates to the same frame in the same cycle.
module wsclock_frame_table #(
    parameter int NF  = 16,
    parameter int TW  = 16,
    parameter int NT  = 4,
    localparam int IDX_W = $clog2(NF),
    localparam int TKW   = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             sw_clr_used,
    input  logic             sw_load_time,
    input  logic [TW-1:0]    sw_time_val,
    input  logic             sw_clr_dirty,
    input  logic             mark_valid,
    input  logic [IDX_W-1:0] mark_frame,
    input  logic             mark_used,
    input  logic             mark_dirty,
    input  logic             init_valid,
    input  logic [IDX_W-1:0] init_frame,
    input  logic [TW-1:0]    init_time,
    input  logic [TKW-1:0]   init_task,
    output logic             rd_used,
    output logic             rd_dirty,
    output logic [TW-1:0]    rd_time,
    output logic [TKW-1:0]   rd_owner
);
    logic          used_q  [NF];
    logic          dirty_q [NF];
    logic [TW-1:0] time_q  [NF];
    logic [TKW-1:0] owner_q [NF];

    for (genvar g = 0; g < NF; g++) begin : g_frame
        localparam logic [IDX_W-1:0] MY = IDX_W'(g);
        logic hit_sw, hit_mark, hit_init;
        assign hit_sw   = (rd_idx == MY);
        assign hit_mark = mark_valid && (mark_frame == MY);
        assign hit_init = init_valid && (init_frame == MY);

        // Used flag: mark sets, sweep clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                        used_q[g] <= 1'b0;
            else if (hit_mark && mark_used)    used_q[g] <= 1'b1;
            else if (hit_sw && sw_clr_used)    used_q[g] <= 1'b0;
        end

        // Dirty flag: mark sets, accepted write-back clears.
        always_ff @(posedge clk) begin
            if (!rst_n)                        dirty_q[g] <= 1'b0;
            else if (hit_mark && mark_dirty)   dirty_q[g] <= 1'b1;
            else if (hit_sw && sw_clr_dirty)   dirty_q[g] <= 1'b0;
        end

        // Timestamp and owner: init writes, sweep refreshes the timestamp.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                time_q[g]  <= '0;
                owner_q[g] <= '0;
            end else if (hit_init) begin
                time_q[g]  <= init_time;
                owner_q[g] <= init_task;
            end else if (hit_sw && sw_load_time) begin
                time_q[g]  <= sw_time_val;
            end
        end
    end

    assign rd_used  = used_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_time  = time_q[rd_idx];
    assign rd_owner = owner_q[rd_idx];

    assert_mark_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_valid && mark_used) |=> used_q[$past(mark_frame)]);

    assert_init_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (time_q[$past(init_frame)] == $past(init_time)));
endmodule

// File: rtl/wsclock_age_check.sv
// Working-set age test for the frame under the hand.
// Selects the owner's execution time and compares the wrap-safe age with theta.
module wsclock_age_check #(
    parameter int TW = 16,
    parameter int NT = 4,
    localparam int TKW = $clog2(NT)
) (
    input  logic [NT*TW-1:0] exec_times,
    input  logic [TKW-1:0]   owner,
    input  logic [TW-1:0]    stamp,
    input  logic [TW-1:0]    theta,
    output logic [TW-1:0]    owner_exec,
    output logic             old_enough
);
    logic [TW-1:0] age;

    // Owner lookup and modulo-2^TW age comparison.
    always_comb begin
        owner_exec = exec_times[owner*TW +: TW];
        age        = owner_exec - stamp;
        old_enough = (age >= theta);
    end
endmodule

// File: rtl/wsclock_sweep_ctrl.sv
// Sweep controller: owns the hand, walks one frame per cycle, issues
// write-backs for dirty candidates and reports the outcome.
// Assumes frame data for rd_idx is presented combinationally.
module wsclock_sweep_ctrl
    import wsclock_pkg::*;
#(
    parameter int NF = 16,
    localparam int IDX_W = $clog2(NF),
    localparam int CNT_W = $clog2(NF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_req,
    input  logic             cur_used,
    input  logic             cur_dirty,
    input  logic             cur_old,
    input  logic             wb_ready,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sw_clr_used,
    output logic             sw_load_time,
    output logic             sw_clr_dirty,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_frame,
    output logic             busy,
    output logic             done,
    output logic             victim_found,
    output logic [IDX_W-1:0] victim_frame
);
    sweep_state_e     state_q;
    logic [IDX_W-1:0] hand_q, pos_q;
    logic [CNT_W-1:0] seen_q;
    logic             advance;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NF-1)) ? '0 : p + 1'b1;
    endfunction

    // Step to the next frame when the current one is neither chosen nor waiting.
    always_comb begin
        advance = 1'b0;
        if (state_q == ST_SCAN) advance = cur_used || !cur_old;
        else if (state_q == ST_WB) advance = wb_ready;
    end

    // State, hand, position and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            hand_q       <= IDX_W'(NF-1);
            pos_q        <= '0;
            seen_q       <= '0;
            done         <= 1'b0;
            victim_found <= 1'b0;
            victim_frame <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (fault_req) begin
                    pos_q   <= ring_next(hand_q);
                    seen_q  <= '0;
                    state_q <= ST_SCAN;
                end
            end else if (advance) begin
                if (seen_q == CNT_W'(NF-1)) begin
                    done         <= 1'b1;
                    victim_found <= 1'b0;
                    state_q      <= ST_IDLE;
                end else begin
                    pos_q   <= ring_next(pos_q);
                    seen_q  <= seen_q + 1'b1;
                    state_q <= ST_SCAN;
                end
            end else if (state_q == ST_SCAN) begin
                if (cur_dirty) begin
                    state_q <= ST_WB;
                end else begin
                    done         <= 1'b1;
                    victim_found <= 1'b1;
                    victim_frame <= pos_q;
                    hand_q       <= pos_q;
                    state_q      <= ST_IDLE;
                end
            end
        end
    end

    // Frame-table commands and handshake outputs.
    always_comb begin
        rd_idx       = pos_q;
        sw_clr_used  = (state_q == ST_SCAN) && cur_used;
        sw_load_time = (state_q == ST_SCAN) && cur_used;
        sw_clr_dirty = (state_q == ST_WB) && wb_ready;
        wb_valid     = (state_q == ST_WB);
        wb_frame     = pos_q;
        busy         = (state_q != ST_IDLE);
    end

    assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_frame)));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fault_req) |=> busy);
endmodule

// File: rtl/wsclock_victim_sel.sv
// Top: working-set clock victim selector over NF frames.
// Wires frame table, age test and sweep controller together.
module wsclock_victim_sel #(
    parameter int NF = 16,
    parameter int TW = 16,
    parameter int NT = 4,
    localparam int IDX_W = $clog2(NF),
    localparam int TKW   = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_req,
    input  logic [NT*TW-1:0] exec_times,
    input  logic [TW-1:0]    theta,
    input  logic             mark_valid,
    input  logic [IDX_W-1:0] mark_frame,
    input  logic             mark_used,
    input  logic             mark_dirty,
    input  logic             init_valid,
    input  logic [IDX_W-1:0] init_frame,
    input  logic [TW-1:0]    init_time,
    input  logic [TKW-1:0]   init_task,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [IDX_W-1:0] wb_frame,
    output logic             busy,
    output logic             done,
    output logic             victim_found,
    output logic [IDX_W-1:0] victim_frame
);
    logic [IDX_W-1:0] rd_idx;
    logic             sw_clr_used, sw_load_time, sw_clr_dirty;
    logic             cur_used, cur_dirty, cur_old;
    logic [TW-1:0]    cur_time, owner_exec;
    logic [TKW-1:0]   cur_owner;

    wsclock_frame_table #(.NF(NF), .TW(TW), .NT(NT)) u_table (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
        .sw_clr_used(sw_clr_used), .sw_load_time(sw_load_time),
        .sw_time_val(owner_exec), .sw_clr_dirty(sw_clr_dirty),
        .mark_valid(mark_valid), .mark_frame(mark_frame),
        .mark_used(mark_used), .mark_dirty(mark_dirty),
        .init_valid(init_valid), .init_frame(init_frame),
        .init_time(init_time), .init_task(init_task),
        .rd_used(cur_used), .rd_dirty(cur_dirty),
        .rd_time(cur_time), .rd_owner(cur_owner)
    );

    wsclock_age_check #(.TW(TW), .NT(NT)) u_age (
        .exec_times(exec_times), .owner(cur_owner), .stamp(cur_time),
        .theta(theta), .owner_exec(owner_exec), .old_enough(cur_old)
    );

    wsclock_sweep_ctrl #(.NF(NF)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req),
        .cur_used(cur_used), .cur_dirty(cur_dirty), .cur_old(cur_old),
        .wb_ready(wb_ready), .rd_idx(rd_idx),
        .sw_clr_used(sw_clr_used), .sw_load_time(sw_load_time),
        .sw_clr_dirty(sw_clr_dirty), .wb_valid(wb_valid),
        .wb_frame(wb_frame), .busy(busy), .done(done),
        .victim_found(victim_found), .victim_frame(victim_frame)
    );

    assert_wb_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy);
endmodule

// File: tb/wsclock_victim_sel_bench.sv
module wsclock_victim_sel_bench;
    localparam int NF = 16, TW = 16, NT = 4;

    logic        clk = 1'b0, rst_n = 1'b0, fault_req = 1'b0;
    logic [63:0] exec_times = '0;
    logic [15:0] theta = '0;
    logic        mark_valid = 1'b0, mark_used = 1'b0, mark_dirty = 1'b0;
    logic [3:0]  mark_frame = '0;
    logic        init_valid = 1'b0;
    logic [3:0]  init_frame = '0;
    logic [15:0] init_time = '0;
    logic [1:0]  init_task = '0;
    logic        wb_valid, wb_ready = 1'b1, busy, done, victim_found;
    logic [3:0]  wb_frame, victim_frame;

    wsclock_victim_sel u_wsclock_victim_sel (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .exec_times(exec_times),
        .theta(theta), .mark_valid(mark_valid), .mark_frame(mark_frame),
        .mark_used(mark_used), .mark_dirty(mark_dirty), .init_valid(init_valid),
        .init_frame(init_frame), .init_time(init_time), .init_task(init_task),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_frame(wb_frame),
        .busy(busy), .done(done), .victim_found(victim_found),
        .victim_frame(victim_frame)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0, wb_seen = 0;
    bit cmp_on = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_used[NF], m_dirty[NF], m_time[NF], m_owner[NF];
    int m_hand, m_state, m_pos, m_cnt, m_vf;
    bit m_done, m_found;

    always @(posedge clk) begin
        int f, et, age;
        bit adv;
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) begin
                m_used[i] = 0; m_dirty[i] = 0; m_time[i] = 0; m_owner[i] = 0;
            end
            m_hand = NF - 1; m_state = 0; m_pos = 0; m_cnt = 0;
            m_done = 0; m_found = 0; m_vf = 0;
            cmp_on = 1'b1;
        end else begin
            m_done = 0; adv = 0;
            if (m_state == 0) begin
                if (fault_req) begin
                    m_pos = (m_hand + 1) % NF; m_cnt = 0; m_state = 1;
                end
            end else if (m_state == 1) begin
                f  = m_pos;
                et = int'(exec_times[m_owner[f]*TW +: TW]);
                if (m_used[f] != 0) begin
                    m_used[f] = 0; m_time[f] = et; adv = 1;
                end else begin
                    age = (et - m_time[f]) & 16'hFFFF;
                    if (age >= int'(theta)) begin
                        if (m_dirty[f] != 0) m_state = 2;
                        else begin
                            m_done = 1; m_found = 1; m_vf = f; m_hand = f; m_state = 0;
                        end
                    end else adv = 1;
                end
            end else begin
                if (wb_ready) begin m_dirty[m_pos] = 0; adv = 1; end
            end
            if (adv) begin
                if (m_cnt == NF - 1) begin
                    m_done = 1; m_found = 0; m_state = 0;
                end else begin
                    m_pos = (m_pos + 1) % NF; m_cnt++; m_state = 1;
                end
            end
            if (mark_valid) begin
                if (mark_used)  m_used[mark_frame] = 1;
                if (mark_dirty) m_dirty[mark_frame] = 1;
            end
            if (init_valid) begin
                m_time[init_frame] = int'(init_time); m_owner[init_frame] = int'(init_task);
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            check(busy == (m_state != 0), "R9 busy", busy, m_state != 0);
            check(done == m_done, "R6 done", done, m_done);
            check(victim_found == m_found, "R6 victim_found", victim_found, m_found);
            check(int'(victim_frame) == m_vf, "R6 victim_frame", victim_frame, m_vf);
            check(wb_valid == (m_state == 2), "R5 wb_valid", wb_valid, m_state == 2);
            if (wb_valid) check(int'(wb_frame) == m_pos, "R5 wb_frame", wb_frame, m_pos);
            if (wb_valid && wb_ready) wb_seen++;
        end
    end

    task automatic set_exec(input int t, input int v);
        @(negedge clk);
        exec_times[t*TW +: TW] = 16'(v);
    endtask

    task automatic init_one(input int f, input int tm, input int tk);
        @(negedge clk);
        init_valid = 1'b1; init_frame = 4'(f); init_time = 16'(tm); init_task = 2'(tk);
        @(negedge clk);
        init_valid = 1'b0;
    endtask

    task automatic init_all(input int tm);
        for (int f = 0; f < NF; f++) init_one(f, tm, 0);
    endtask

    task automatic mark(input int f, input bit u, input bit d);
        @(negedge clk);
        mark_valid = 1'b1; mark_frame = 4'(f); mark_used = u; mark_dirty = d;
        @(negedge clk);
        mark_valid = 1'b0; mark_used = 1'b0; mark_dirty = 1'b0;
    endtask

    task automatic start_fault();
        @(negedge clk);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        check(busy == 1'b1, "R9 busy after accepted fault", busy, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 300) begin @(negedge clk); n++; end
        check(done == 1'b1, "R6 search finished", done, 1);
    endtask

    task automatic search(input string tag, input bit exp_found, input int exp_frame);
        start_fault();
        wait_done();
        check(victim_found == exp_found, tag, victim_found, exp_found);
        if (exp_found) check(int'(victim_frame) == exp_frame, tag, victim_frame, exp_frame);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !wb_valid && !victim_found, "R1 reset outputs",
              {busy, done, wb_valid, victim_found}, 0);
        rst_n = 1'b1;
        // R1/R6: first fault examines frame 0, which is clean and old enough
        search("R1 first victim", 1'b1, 0);
        // R2: next search starts after the hand
        search("R2 hand advance", 1'b1, 1);
        // R3/R8: frames 2,3 marked used get refreshed and skipped
        set_exec(0, 20);
        mark(2, 1'b1, 1'b0);
        mark(3, 1'b1, 1'b0);
        search("R3 used frames skipped", 1'b1, 4);
        // R3/R7: refreshed stamps (20) fail theta 11 at exec 30; no victim
        set_exec(0, 30);
        theta = 16'd11;
        for (int f = 0; f < NF; f++) if (f != 2 && f != 3) init_one(f, 25, 0);
        search("R7 no victim after refresh", 1'b0, 0);
        // R4: wrap-safe age 5 - 65530 = 11 >= 11; hand stayed at 4
        set_exec(0, 5);
        init_one(5, 65530, 0);
        search("R4 wrap-safe age", 1'b1, 5);
        // R4: owner task 2 supplies the execution time
        init_all(5);
        init_one(7, 0, 2);
        set_exec(2, 1000);
        theta = 16'd500;
        search("R4 owner selects exec time", 1'b1, 7);
        // R5: dirty candidate stalls on wb_ready low, then skipped
        set_exec(0, 100);
        set_exec(2, 100);
        theta = 16'd50;
        init_all(100);
        init_one(8, 0, 0);
        init_one(9, 0, 0);
        mark(8, 1'b0, 1'b1);
        wb_ready = 1'b0;
        start_fault();
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(wb_valid && wb_frame == 4'd8, "R5 stalled write-back", wb_frame, 8);
            fault_req = (k == 1);
            @(negedge clk);
        end
        fault_req = 1'b0;
        wb_ready = 1'b1;
        wait_done();
        check(victim_found && victim_frame == 4'd9, "R5 dirty skipped", victim_frame, 9);
        @(negedge clk);
        check(busy == 1'b0, "R2 fault while busy ignored", busy, 0);
        // R5: dirty flag of frame 8 cleared by the accepted write-back
        init_all(100);
        init_one(8, 0, 0);
        wb_seen = 0;
        search("R5 dirty cleared", 1'b1, 8);
        check(wb_seen == 0, "R5 no write-back for cleaned frame", wb_seen, 0);
        // R7: full lap of dirty candidates, all written back, no victim
        theta = 16'd0;
        for (int f = 0; f < NF; f++) mark(f, 1'b0, 1'b1);
        wb_seen = 0;
        search("R7 lap of write-backs", 1'b0, 0);
        check(wb_seen == NF, "R7 write-back count", wb_seen, NF);
        search("R7 hand unchanged", 1'b1, 9);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule